// File: doc/BRIEF.md
# Zero-Crossing Volume Attenuator with Timeout

This block scales a stream of 16-bit two's-complement audio samples by a programmable attenuation. The setting is a 6-bit code that selects a loss from 0 dB to -94.5 dB in 1.5 dB steps. A separate mute bit forces silence. Each channel has its own setting and can be changed on its own. All channels share one sample strobe.

A newly requested setting does not take effect at once. It is held as pending until the signal on that channel crosses zero, so that the level never jumps in the middle of a waveform and causes zipper noise. If no crossing arrives within a fixed number of sample strobes, a per-channel timer forces the change. A host writes a request per channel. The pending value is applied to the first sample that qualifies, and the scaled sample appears one clock after its strobe.

Top module: `zc_vol_atten`

## Requirements
- R1: After reset, `outValid` is 0 and `sampleOut` is all zero. Every channel starts at code 0, unmuted (unity gain), with nothing pending and the remembered sign set to non-negative.
- R2: One clock after a cycle with `inValid`=1, `outValid` is 1 and `sampleOut` carries the result. After a cycle without a strobe, `outValid` is 0 and `sampleOut` holds its value.
- R3: With code c (0..63) and unmuted, the output is floor(x*M/2^(15+floor(c/4))). M is 32768, 27571, 23198 or 19519 for c mod 4 = 0, 1, 2, 3. Code 0 passes the sample unchanged.
- R4: With mute in effect, the output sample is 0 whatever the code.
- R5: A request (`reqValid` bit of a channel, with its code in `reqCode` bits [6*ch+5:6*ch] and its mute bit) is only stored as pending. A sample that is not a zero crossing keeps the previous setting.
- R6: A sample is a zero crossing when it equals zero, or when its sign bit (bit 15) differs from the sign bit of that channel's previous strobed sample. A pending setting is applied to the crossing sample itself.
- R7: If no crossing comes, the pending setting is applied to the 512th sample strobe after the request.
- R8: A request that arrives while a change is pending replaces the pending value and restarts the timer. On a cycle that carries both a request and a strobe, that channel applies nothing, and the strobe is still scaled with the active setting.
- R9: Each channel has its own pending value, timer and crossing detector. A crossing or a request on one channel does not affect another channel.
- R10: The remembered sign is updated by every strobed sample, whether or not anything is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Sample strobe shared by all channels |
| sampleIn | input | NUM_CH*DATA_W | Input samples, channel ch in bits [16*ch+15:16*ch] |
| reqValid | input | NUM_CH | Per-channel setting request strobe |
| reqCode | input | NUM_CH*6 | Per-channel requested attenuation code (1.5 dB per step) |
| reqMute | input | NUM_CH | Per-channel requested mute |
| outValid | output | 1 | Output sample strobe |
| sampleOut | output | NUM_CH*DATA_W | Attenuated samples |

## Verification
The assertions check local rules on every cycle:
- the output strobe follows the input strobe by one clock;
- the output is zero under mute and passes the sample unchanged at code 0;
- the output holds between strobes and the scaled result never overflows;
- a request always becomes pending, and an apply only happens on a strobe and then clears the pending state;
- the timer rests at zero when nothing is pending.

The bench scenarios are needed for the rules that depend on history: the exact strobe on which a change lands, whether for a crossing, at the 512th strobe or after a restart by a replaced request; the separation of the channels; and the arithmetic of all 64 codes against independently computed values.

// File: rtl/zc_vol_pkg.sv
package zc_vol_pkg;
  localparam int CODE_W = 6;

  typedef struct packed {
    logic              apply;
    logic              mute;
    logic [CODE_W-1:0] code;
  } gainCmd_t;
endpackage

// File: rtl/zc_vol_ctrl.sv
module zc_vol_ctrl
  import zc_vol_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] sample,
  input  logic              reqValid,
  input  logic [CODE_W-1:0] reqCode,
  input  logic              reqMute,
  output gainCmd_t          cmd
);
  localparam int TMR_W = $clog2(TIMEOUT);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  logic              pendValid;
  logic              pendMute;
  logic [CODE_W-1:0] pendCode;
  logic [TMR_W-1:0]  timer;
  logic              prevNeg;

  logic curNeg, isZero, crossing, expired, applyNow;

  always_comb begin
    curNeg   = sample[DATA_W-1];
    isZero   = (sample == '0);
    crossing = isZero | (curNeg ^ prevNeg);
    expired  = (timer == TMR_LAST);
    applyNow = inValid & pendValid & ~reqValid & (crossing | expired);
    cmd.apply = applyNow;
    cmd.mute  = pendMute;
    cmd.code  = pendCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendMute  <= 1'b0;
      pendCode  <= '0;
      timer     <= '0;
      prevNeg   <= 1'b0;
    end else begin
      if (reqValid) begin
        pendValid <= 1'b1;
        pendMute  <= reqMute;
        pendCode  <= reqCode;
        timer     <= '0;
      end else if (applyNow) begin
        pendValid <= 1'b0;
        timer     <= '0;
      end else if (inValid && pendValid) begin
        timer <= timer + 1'b1;
      end
      if (inValid) prevNeg <= curNeg;
    end
  end

  AST_REQ_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (pendValid && pendCode == $past(reqCode) && pendMute == $past(reqMute))); // R5
  AST_APPLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.apply |=> !pendValid); // R6
  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |-> (timer == '0)); // R7
  AST_REQ_BLOCKS_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !cmd.apply); // R8
endmodule

// File: rtl/zc_vol_dp.sv
module zc_vol_dp
  import zc_vol_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MANT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  gainCmd_t          cmd,
  output logic [DATA_W-1:0] sampleOut
);
  localparam int FRAC   = MANT_W - 1;
  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam int SH_W   = $clog2(FRAC + (2 ** (CODE_W - 2)) + 1);
  localparam logic [MANT_W-1:0] MANT0 = MANT_W'(2 ** FRAC);
  localparam logic [MANT_W-1:0] MANT1 = MANT_W'($rtoi((2.0 ** FRAC) * 0.8413951416 + 0.5));
  localparam logic [MANT_W-1:0] MANT2 = MANT_W'($rtoi((2.0 ** FRAC) * 0.7079457844 + 0.5));
  localparam logic [MANT_W-1:0] MANT3 = MANT_W'($rtoi((2.0 ** FRAC) * 0.5956621435 + 0.5));

  logic              actMute;
  logic [CODE_W-1:0] actCode;

  logic                     effMute;
  logic [CODE_W-1:0]        effCode;
  logic [MANT_W-1:0]        mant;
  logic [SH_W-1:0]          shAmt;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  always_comb begin
    effMute = cmd.apply ? cmd.mute : actMute;
    effCode = cmd.apply ? cmd.code : actCode;
    case (effCode[1:0])
      2'd0:    mant = MANT0;
      2'd1:    mant = MANT1;
      2'd2:    mant = MANT2;
      default: mant = MANT3;
    endcase
    shAmt  = SH_W'(FRAC) + SH_W'(effCode[CODE_W-1:2]);
    prod   = $signed(sampleIn) * $signed({1'b0, mant});
    scaled = prod >>> shAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actMute   <= 1'b0;
      actCode   <= '0;
      sampleOut <= '0;
    end else begin
      if (inValid) sampleOut <= effMute ? '0 : scaled[DATA_W-1:0];
      if (cmd.apply) begin
        actMute <= cmd.mute;
        actCode <= cmd.code;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !effMute) |-> (scaled[PROD_W-1:DATA_W-1] == '0 || scaled[PROD_W-1:DATA_W-1] == '1)); // R3
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !effMute && effCode == '0) |=> (sampleOut == $past(sampleIn))); // R3
  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && effMute) |=> (sampleOut == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(sampleOut)); // R2
  AST_APPLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.apply |-> inValid); // R6
endmodule

// File: rtl/zc_vol_atten.sv
module zc_vol_atten
  import zc_vol_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [NUM_CH*DATA_W-1:0] sampleIn,
  input  logic [NUM_CH-1:0]        reqValid,
  input  logic [NUM_CH*CODE_W-1:0] reqCode,
  input  logic [NUM_CH-1:0]        reqMute,
  output logic                     outValid,
  output logic [NUM_CH*DATA_W-1:0] sampleOut
);
  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    gainCmd_t cmdCh;

    zc_vol_ctrl #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) uCtrl (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (inValid),
      .sample   (sampleIn[ch*DATA_W +: DATA_W]),
      .reqValid (reqValid[ch]),
      .reqCode  (reqCode[ch*CODE_W +: CODE_W]),
      .reqMute  (reqMute[ch]),
      .cmd      (cmdCh)
    );

    zc_vol_dp #(.DATA_W(DATA_W)) uDp (
      .clk       (clk),
      .rstN      (rstN),
      .inValid   (inValid),
      .sampleIn  (sampleIn[ch*DATA_W +: DATA_W]),
      .cmd       (cmdCh),
      .sampleOut (sampleOut[ch*DATA_W +: DATA_W])
    );
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outValid == $past(inValid))); // R2
endmodule

// File: tb/tb_zc_vol_atten.sv
module tb_zc_vol_atten;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid;
  logic [31:0] sampleIn;
  logic [1:0]  reqValid;
  logic [11:0] reqCode;
  logic [1:0]  reqMute;
  logic        outValid;
  logic [31:0] sampleOut;

  always #2 clk = ~clk;

  bit iv = 0;
  int xv[2] = '{0, 0};
  bit rv[2] = '{0, 0};
  int rc[2] = '{0, 0};
  bit rm[2] = '{0, 0};

  assign inValid  = iv;
  assign sampleIn = {16'(xv[1]), 16'(xv[0])};
  assign reqValid = {rv[1], rv[0]};
  assign reqCode  = {6'(rc[1]), 6'(rc[0])};
  assign reqMute  = {rm[1], rm[0]};

  zc_vol_atten dut (.*);

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural model state
  int actCode[2] = '{0, 0};
  bit actMute[2] = '{0, 0};
  bit pend[2] = '{0, 0};
  int pendCode[2] = '{0, 0};
  bit pendMute[2] = '{0, 0};
  int tmr[2] = '{0, 0};
  bit prevNeg[2] = '{0, 0};
  int expOut[2] = '{0, 0};
  bit expValid = 0;

  function automatic int gainOf(int x, int c, bit m);
    longint p;
    int mt;
    if (m) return 0;
    case (c % 4)
      0: mt = 32768;
      1: mt = 27571;
      2: mt = 23198;
      default: mt = 19519;
    endcase
    p = longint'(x) * mt;
    p = p >>> (15 + c / 4);
    return int'(p);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    for (int ch = 0; ch < 2; ch++) begin
      bit neg = (xv[ch] < 0);
      bit apply = iv && pend[ch] && !rv[ch] && (xv[ch] == 0 || neg != prevNeg[ch] || tmr[ch] == 511);
      int ec = apply ? pendCode[ch] : actCode[ch];
      bit em = apply ? pendMute[ch] : actMute[ch];
      if (iv) expOut[ch] = gainOf(xv[ch], ec, em);
      if (rv[ch]) begin
        pend[ch] = 1; pendCode[ch] = rc[ch]; pendMute[ch] = rm[ch]; tmr[ch] = 0;
      end else if (apply) begin
        actCode[ch] = pendCode[ch]; actMute[ch] = pendMute[ch]; pend[ch] = 0; tmr[ch] = 0;
      end else if (iv && pend[ch]) begin
        tmr[ch]++;
      end
      if (iv) prevNeg[ch] = neg;
    end
    expValid = iv;
    @(posedge clk);
    #1;
    check(curReq, int'(outValid), int'(expValid));
    for (int ch = 0; ch < 2; ch++)
      check(curReq, int'($signed(sampleOut[ch*16 +: 16])), expOut[ch]);
    iv = 0; rv[0] = 0; rv[1] = 0;
  endtask

  task automatic sampleBoth(int x0, int x1);
    iv = 1; xv[0] = x0; xv[1] = x1; step();
  endtask

  task automatic request(int ch, int c, bit m);
    rv[ch] = 1; rc[ch] = c; rm[ch] = m; step();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    // R1: reset state visible at the ports
    check("R1", int'(outValid), 0);
    check("R1", int'(sampleOut), 0);

    // R10 and R6: initial remembered sign is non-negative, so a first negative sample crosses
    curReq = "R10";
    request(0, 8, 0);
    sampleBoth(-1000, 1234);   // ch0 applies code 8, ch1 unity (R3)

    // R2: gap between strobes, outputs hold
    curReq = "R2";
    step(); step();
    sampleBoth(-32768, 32767);

    // R5: pending while sign stays the same
    curReq = "R5";
    request(1, 5, 0);
    for (int i = 0; i < 4; i++) sampleBoth(-500 - i, 3000 + i * 100);
    // R6: sign change applies to the crossing sample
    curReq = "R6";
    sampleBoth(-700, -3000);
    sampleBoth(-700, -2500);

    // R4: mute applied on an exact zero sample, then stays silent
    curReq = "R4";
    request(0, 0, 1);
    sampleBoth(0, -100);
    sampleBoth(20000, -200);
    sampleBoth(-20000, -300);

    // R7: timeout forces change after 512 strobes without crossing
    curReq = "R7";
    request(0, 0, 0);
    request(1, 20, 0);
    for (int i = 0; i < 520; i++) sampleBoth(-15000, -15000 + i);

    // R8: replacement restarts the timer
    curReq = "R8";
    request(0, 13, 0);
    for (int i = 0; i < 300; i++) sampleBoth(-9000, -100);
    request(0, 30, 0);
    for (int i = 0; i < 520; i++) sampleBoth(-9000 - i, -100);
    // R8: request coinciding with a strobe suppresses application that cycle
    rv[0] = 1; rc[0] = 2; rm[0] = 0;
    iv = 1; xv[0] = 5000; xv[1] = 100;
    step();
    sampleBoth(-5000, 100);

    // R9: crossing on one channel leaves the other channel pending
    curReq = "R9";
    request(0, 40, 0);
    request(1, 40, 0);
    sampleBoth(6000, 100);
    sampleBoth(6000, 200);
    sampleBoth(-6000, -200);

    // R3: all 64 codes with alternating signs
    curReq = "R3";
    for (int c = 0; c < 64; c++) begin
      int mag = (c % 3 == 0) ? 32767 : 1 + c * 509;
      request(0, c, 0);
      request(1, 63 - c, 0);
      if (c % 2 == 0) sampleBoth(mag, -mag);
      else            sampleBoth(-mag, mag);
      if (c % 2 == 0) sampleBoth(-mag - 1, mag - 1);
      else            sampleBoth(mag - 1, -mag - 1);
    end
    sampleBoth(-32768, -32768);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule